// File: doc/BRIEF.md
# Queued DMA Command Engine

This block is a small, register-programmed copy engine. Software loads a source address, a destination address and two lengths (counted in 32-bit words) into a write-only-style register window. Writing the destination length is the trigger: it snapshots all four values into a command queue. A mover takes the command at the head of the queue and streams it over a word-wide memory master port. The mover works in chunks of at most `CHUNK_BYTES`. In loopback mode, each word read from the source is written back out at the destination. Without loopback, the source is only read.

When a command finishes, two interrupt status bits are raised together and the command leaves the queue. Status bits are cleared by writing ones. A mask register gates them onto a single level-sensitive interrupt line. A read-only status word shows whether the queue is full or empty.

The memory port is valid/ready. A request (read or write, one word) is presented with `m_req_valid`, and the block holds address, direction and write data unchanged until `m_req_ready` is seen high at a clock edge. After a read request is accepted, the block raises `m_rsp_ready` and waits for one `m_rsp_valid` beat carrying the data. Only one read is outstanding at a time, so the memory side may stall either channel for any number of cycles.

Top module: `cqdma_top`

## Requirements
- R1: After reset the interrupt status word (offset 0x0C) reads 0x8802_0000, the mask word (0x10) reads 0xFFFF_FFFF, the queue status word (0x14) reads 0x4000_0000, and `irq` is low.
- R2: A write to offset 0x24 enqueues one command built from the source address (0x18), destination address (0x1C), source length (0x20) and the value being written. Both addresses have bits 1:0 forced to zero. Lengths count words and become bytes ×4. Only bits 26:0 of a length register are stored, so writing all ones reads back 0x07FF_FFFF.
- R3: With loopback off (offset 0x80 bit 4 clear), a command issues only read requests (`m_req_we`=0), one per word, at ascending word addresses from the source.
- R4: With loopback on (offset 0x80 bit 4 set, read back at the same bit), each source read is followed by a write (`m_req_we`=1) of the same data to the next destination word address.
- R5: A command is split into chunks. Each chunk is limited to `CHUNK_BYTES` (1024) and to the remaining source bytes, and also to the remaining destination bytes when loopback is on. The loopback setting is sampled only when a chunk starts, so a change takes effect at the next chunk boundary.
- R6: When the remaining source and destination lengths are both zero, the head command retires: status bits 13 and 12 are set in the same cycle and the queue entry is freed. A command with both lengths zero retires without any memory access.
- R7: The queue holds `QUEUE_DEPTH` (10) commands, including the one being moved. Status bit 31 reads 1 when the queue is full, and bit 30 reads 1 when it is empty.
- R8: A trigger write while the queue is full drops the command and sets status bit 14.
- R9: Writing a one to an interrupt status bit clears it. Bits 26:24 and bit 19 are reserved: they always read zero.
- R10: `irq` is high exactly when some interrupt status bit is set whose mask bit is zero.
- R11: If a chunk would be zero bytes while the command has not both lengths at zero, the command stays at the head, issues no accesses and never retires.
- R12: While `m_req_valid` is high and `m_req_ready` is low, the request address, direction and data are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (reads are combinational) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt, OR of unmasked status bits |
| m_req_valid | output | 1 | Memory request valid |
| m_req_ready | input | 1 | Memory request accepted |
| m_req_we | output | 1 | 1 = write request, 0 = read request |
| m_req_addr | output | 32 | Word-aligned byte address |
| m_req_wdata | output | 32 | Write data |
| m_rsp_valid | input | 1 | Read data valid |
| m_rsp_ready | output | 1 | Block waiting for read data |
| m_rsp_data | input | 32 | Read data |

## Verification
The bench goes after three kinds of mistake.

The first is a loopback command long enough to cross a chunk boundary, with loopback switched off during the first chunk. The 256 read/write pairs must be followed by 44 bare reads, and then the command must stall. A design that samples the mode bit every word would drop writes early. A design that ignores the destination remainder would retire the command falsely.

The second is a queue held full by a stalled memory port, with one extra trigger. The eleventh command must vanish and raise the overflow bit. An off-by-one depth would either accept it or report full one entry early.

The third is zero-length commands, unaligned addresses and the write-one-to-clear path with the mask. A wrong implementation of these shows up as a spurious access, a misaligned address, or an interrupt that stays high after clearing or rises while masked.

// File: rtl/cqdma_pkg.sv
package cqdma_pkg;

  parameter int unsigned ADDR_W = 32;
  parameter int unsigned LEN_W  = 27;
  localparam int unsigned BLEN_W = LEN_W + 2;

  // register offsets
  localparam logic [7:0] OFS_ISTS  = 8'h0C;
  localparam logic [7:0] OFS_IMASK = 8'h10;
  localparam logic [7:0] OFS_QSTAT = 8'h14;
  localparam logic [7:0] OFS_SRC   = 8'h18;
  localparam logic [7:0] OFS_DST   = 8'h1C;
  localparam logic [7:0] OFS_SLEN  = 8'h20;
  localparam logic [7:0] OFS_DLEN  = 8'h24;
  localparam logic [7:0] OFS_MODE  = 8'h80;

  // bit positions
  localparam int unsigned BIT_DONE  = 13;
  localparam int unsigned BIT_PDONE = 12;
  localparam int unsigned BIT_QOVF  = 14;
  localparam int unsigned BIT_FULL  = 31;
  localparam int unsigned BIT_EMPTY = 30;
  localparam int unsigned BIT_LOOP  = 4;

  localparam logic [31:0] ISTS_RESET = 32'h8802_0000;
  localparam logic [31:0] ISTS_RSVD  = 32'h0708_0000;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [BLEN_W-1:0] slen;
    logic [BLEN_W-1:0] dlen;
  } cmd_t;

endpackage

// File: rtl/cqdma_cmd_queue.sv
module cqdma_cmd_queue
  import cqdma_pkg::*;
#(
  parameter int unsigned DEPTH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t push_cmd,
  input  logic pop,
  output cmd_t head,
  output logic full,
  output logic empty
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  cmd_t          slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_cmd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + PW'(1);
      if (pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + PW'(1);
      case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head  = slot_q[rd_ptr_q];
  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);

endmodule

// File: rtl/cqdma_regfile.sv
module cqdma_regfile
  import cqdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        q_full,
  input  logic        q_empty,
  input  logic        retire,
  output logic        push_req,
  output cmd_t        push_cmd,
  output logic        loopback,
  output logic [31:0] int_sts,
  output logic [31:0] int_mask
);

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  slen_q, dlen_q;
  logic              loop_q;
  logic [31:0]       sts_q, mask_q;
  logic [31:0]       sts_set, sts_clr, sts_d;

  logic wr_sts, wr_mask, wr_src, wr_dst, wr_slen, wr_dlen, wr_mode;

  assign wr_sts  = wr_en && (addr == OFS_ISTS);
  assign wr_mask = wr_en && (addr == OFS_IMASK);
  assign wr_src  = wr_en && (addr == OFS_SRC);
  assign wr_dst  = wr_en && (addr == OFS_DST);
  assign wr_slen = wr_en && (addr == OFS_SLEN);
  assign wr_dlen = wr_en && (addr == OFS_DLEN);
  assign wr_mode = wr_en && (addr == OFS_MODE);

  // trigger: snapshot of the four DMA values, dst length taken from the bus
  assign push_req      = wr_dlen;
  assign push_cmd.src  = {src_q[ADDR_W-1:2], 2'b00};
  assign push_cmd.dst  = {dst_q[ADDR_W-1:2], 2'b00};
  assign push_cmd.slen = {slen_q, 2'b00};
  assign push_cmd.dlen = {wdata[LEN_W-1:0], 2'b00};

  always_comb begin
    sts_set = '0;
    if (retire) begin
      sts_set[BIT_DONE]  = 1'b1;
      sts_set[BIT_PDONE] = 1'b1;
    end
    if (push_req && q_full) sts_set[BIT_QOVF] = 1'b1;
    sts_clr = wr_sts ? (wdata & ~ISTS_RSVD) : '0;
    sts_d   = ((sts_q & ~sts_clr) | sts_set) & ~ISTS_RSVD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      slen_q <= '0;
      dlen_q <= '0;
      loop_q <= 1'b0;
      sts_q  <= ISTS_RESET;
      mask_q <= '1;
    end else begin
      sts_q <= sts_d;
      if (wr_mask) mask_q <= wdata;
      if (wr_src)  src_q  <= wdata;
      if (wr_dst)  dst_q  <= wdata;
      if (wr_slen) slen_q <= wdata[LEN_W-1:0];
      if (wr_dlen) dlen_q <= wdata[LEN_W-1:0];
      if (wr_mode) loop_q <= wdata[BIT_LOOP];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_ISTS:  rdata = sts_q;
      OFS_IMASK: rdata = mask_q;
      OFS_QSTAT: begin
        rdata[BIT_FULL]  = q_full;
        rdata[BIT_EMPTY] = q_empty;
      end
      OFS_SRC:   rdata = src_q;
      OFS_DST:   rdata = dst_q;
      OFS_SLEN:  rdata = {{(32-LEN_W){1'b0}}, slen_q};
      OFS_DLEN:  rdata = {{(32-LEN_W){1'b0}}, dlen_q};
      OFS_MODE:  rdata[BIT_LOOP] = loop_q;
      default:   rdata = '0;
    endcase
  end

  assign loopback = loop_q;
  assign int_sts  = sts_q;
  assign int_mask = mask_q;

endmodule

// File: rtl/cqdma_mover.sv
module cqdma_mover
  import cqdma_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  cmd_t              head,
  input  logic              loopback,
  output logic              retire,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data
);

  localparam int unsigned WORDS_MAX = CHUNK_BYTES / 4;
  localparam int unsigned WCW = $clog2(WORDS_MAX) + 1;
  localparam logic [BLEN_W-1:0] CHUNK_LIM = BLEN_W'(CHUNK_BYTES);

  typedef enum logic [2:0] {MV_IDLE, MV_PLAN, MV_RD, MV_RSP, MV_WR} mv_state_e;

  mv_state_e         state_q;
  logic [ADDR_W-1:0] src_a_q, dst_a_q;
  logic [BLEN_W-1:0] src_r_q, dst_r_q;
  logic [WCW-1:0]    words_q;
  logic              lb_q;
  logic [31:0]       data_q;

  logic [BLEN_W-1:0] lim;
  logic              both_zero;
  logic              last_word;

  // chunk size for the next burst of words
  always_comb begin
    lim = CHUNK_LIM;
    if (src_r_q < lim) lim = src_r_q;
    if (loopback && (dst_r_q < lim)) lim = dst_r_q;
  end

  assign both_zero = (src_r_q == '0) && (dst_r_q == '0);
  assign last_word = (words_q == WCW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      src_a_q <= '0;
      dst_a_q <= '0;
      src_r_q <= '0;
      dst_r_q <= '0;
      words_q <= '0;
      lb_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE: begin
          if (!q_empty) begin
            src_a_q <= head.src;
            dst_a_q <= head.dst;
            src_r_q <= head.slen;
            dst_r_q <= head.dlen;
            state_q <= MV_PLAN;
          end
        end
        MV_PLAN: begin
          if (both_zero) begin
            state_q <= MV_IDLE;
          end else if (lim != '0) begin
            words_q <= WCW'(lim >> 2);
            lb_q    <= loopback;
            state_q <= MV_RD;
          end
        end
        MV_RD: begin
          if (req_ready) state_q <= MV_RSP;
        end
        MV_RSP: begin
          if (rsp_valid) begin
            data_q  <= rsp_data;
            src_a_q <= src_a_q + ADDR_W'(4);
            src_r_q <= src_r_q - BLEN_W'(4);
            if (lb_q) begin
              state_q <= MV_WR;
            end else begin
              words_q <= words_q - WCW'(1);
              state_q <= last_word ? MV_PLAN : MV_RD;
            end
          end
        end
        MV_WR: begin
          if (req_ready) begin
            dst_a_q <= dst_a_q + ADDR_W'(4);
            dst_r_q <= dst_r_q - BLEN_W'(4);
            words_q <= words_q - WCW'(1);
            state_q <= last_word ? MV_PLAN : MV_RD;
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign retire    = (state_q == MV_PLAN) && both_zero;
  assign req_valid = (state_q == MV_RD) || (state_q == MV_WR);
  assign req_we    = (state_q == MV_WR);
  assign req_addr  = (state_q == MV_WR) ? dst_a_q : src_a_q;
  assign req_wdata = data_q;
  assign rsp_ready = (state_q == MV_RSP);

endmodule

// File: rtl/cqdma_top.sv
module cqdma_top
  import cqdma_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 10,
  parameter int unsigned CHUNK_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic              m_req_we,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [31:0]       m_req_wdata,
  input  logic              m_rsp_valid,
  output logic              m_rsp_ready,
  input  logic [31:0]       m_rsp_data
);

  logic        push_req, q_push, q_full, q_empty, retire, loopback;
  cmd_t        push_cmd, head_cmd;
  logic [31:0] int_sts, int_mask;

  assign q_push = push_req & ~q_full;
  assign irq    = |(int_sts & ~int_mask);

  cqdma_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .retire   (retire),
    .push_req (push_req),
    .push_cmd (push_cmd),
    .loopback (loopback),
    .int_sts  (int_sts),
    .int_mask (int_mask)
  );

  cqdma_cmd_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (q_push),
    .push_cmd (push_cmd),
    .pop      (retire),
    .head     (head_cmd),
    .full     (q_full),
    .empty    (q_empty)
  );

  cqdma_mover #(.CHUNK_BYTES(CHUNK_BYTES)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_empty   (q_empty),
    .head      (head_cmd),
    .loopback  (loopback),
    .retire    (retire),
    .req_valid (m_req_valid),
    .req_ready (m_req_ready),
    .req_we    (m_req_we),
    .req_addr  (m_req_addr),
    .req_wdata (m_req_wdata),
    .rsp_valid (m_rsp_valid),
    .rsp_ready (m_rsp_ready),
    .rsp_data  (m_rsp_data)
  );

endmodule

// File: rtl/cqdma_checker.sv
module cqdma_checker
  import cqdma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              irq,
  input logic [31:0]       sts,
  input logic [31:0]       mask,
  input logic              q_full,
  input logic              q_empty,
  input logic              push_req,
  input logic              retire
);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !q_empty);

  assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && q_full |=> sts[BIT_QOVF]);

  assert_retire_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> sts[BIT_DONE] && sts[BIT_PDONE]);

  assert_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !req_valid && !retire);

  assert_masked_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 32'hFFFF_FFFF) |-> !irq);

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ISTS_RSVD) == 32'h0);

endmodule

bind cqdma_top cqdma_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (m_req_valid),
  .req_ready (m_req_ready),
  .req_we    (m_req_we),
  .req_addr  (m_req_addr),
  .req_wdata (m_req_wdata),
  .irq       (irq),
  .sts       (int_sts),
  .mask      (int_mask),
  .q_full    (q_full),
  .q_empty   (q_empty),
  .push_req  (push_req),
  .retire    (retire)
);

// File: tb/cqdma_top_bench.sv
module cqdma_top_bench;

  localparam logic [7:0] A_ISTS  = 8'h0C;
  localparam logic [7:0] A_IMASK = 8'h10;
  localparam logic [7:0] A_QSTAT = 8'h14;
  localparam logic [7:0] A_SRC   = 8'h18;
  localparam logic [7:0] A_DST   = 8'h1C;
  localparam logic [7:0] A_SLEN  = 8'h20;
  localparam logic [7:0] A_DLEN  = 8'h24;
  localparam logic [7:0] A_MODE  = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        m_req_valid, m_req_we, m_rsp_ready;
  logic        m_req_ready = 1'b0;
  logic [31:0] m_req_addr, m_req_wdata;
  logic        m_rsp_valid = 1'b0;
  logic [31:0] m_rsp_data = '0;

  cqdma_top u_cqdma_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_we(m_req_we),
    .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready), .m_rsp_data(m_rsp_data)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;

  acc_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   wr_seen = 0;
  bit   stall = 1'b0;
  bit   done_flag = 1'b0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'hA5C3_0F96;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_exp(input bit we, input logic [31:0] a, input logic [31:0] d);
    acc_t e;
    e.we = we; e.addr = a; e.data = d;
    exp_q.push_back(e);
  endtask

  // driver: builds the expected access stream from the requirements, then triggers
  task automatic issue(input logic [31:0] src, input logic [31:0] dst, input int sw,
                       input int dw, input bit lb, input bit expect_it);
    int s, d, c;
    logic [31:0] sa, da;
    if (expect_it) begin
      s = sw * 4; d = dw * 4; sa = src & ~32'h3; da = dst & ~32'h3;
      while (!(s == 0 && d == 0)) begin
        c = 1024;
        if (s < c) c = s;
        if (lb && d < c) c = d;
        if (c == 0) break;
        for (int w = 0; w < c / 4; w++) begin
          push_exp(1'b0, sa, 32'h0);
          if (lb) begin
            push_exp(1'b1, da, mem_word(sa));
            da += 4; d -= 4;
          end
          sa += 4; s -= 4;
        end
      end
    end
    reg_write(A_SRC, src);
    reg_write(A_DST, dst);
    reg_write(A_SLEN, sw);
    reg_write(A_DLEN, dw);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  // memory model and monitor (scoreboard pop side)
  bit          rd_pend = 1'b0, fire_pend = 1'b0;
  logic [31:0] rd_addr = '0;
  always @(negedge clk) begin
    bit rdy;
    acc_t e;
    if (fire_pend) begin m_rsp_valid = 1'b0; fire_pend = 1'b0; end
    if (rd_pend) begin
      m_rsp_valid = 1'b1; m_rsp_data = mem_word(rd_addr); rd_pend = 1'b0;
    end
    if (m_rsp_valid && m_rsp_ready) fire_pend = 1'b1;
    rdy = !stall && ((cyc % 4) != 3);
    m_req_ready = rdy;
    if (rst_n && m_req_valid && rdy) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 R4 R11 unexpected access: actual we=%0b addr=%h expected none",
                 m_req_we, m_req_addr);
      end else begin
        e = exp_q.pop_front();
        if (m_req_we !== e.we || m_req_addr !== e.addr || (e.we && m_req_wdata !== e.data)) begin
          errors++;
          $display("FAIL R3 R4 R5 access: actual we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                   m_req_we, m_req_addr, m_req_wdata, e.we, e.addr, e.data);
        end
      end
      if (!m_req_we) begin rd_pend = 1'b1; rd_addr = m_req_addr; end
      else wr_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(A_ISTS, rd);  check32("R1 int status reset", rd, 32'h8802_0000);
    reg_read(A_IMASK, rd); check32("R1 mask reset", rd, 32'hFFFF_FFFF);
    reg_read(A_QSTAT, rd); check32("R1 queue status reset", rd, 32'h4000_0000);
    check32("R1 irq reset", {31'b0, irq}, 32'h0);

    // R9 write-one-to-clear of everything
    reg_write(A_ISTS, 32'hFFFF_FFFF);
    reg_read(A_ISTS, rd); check32("R9 clear all", rd, 32'h0);

    // R2 length field width
    reg_write(A_SLEN, 32'hFFFF_FFFF);
    reg_read(A_SLEN, rd); check32("R2 length readback", rd, 32'h07FF_FFFF);

    // R3 R2 plain read command, unaligned source
    issue(32'h0000_1003, 32'h0, 5, 0, 1'b0, 1'b1);
    drain();
    reg_read(A_ISTS, rd);  check32("R6 done bits", rd, 32'h0000_3000);
    reg_read(A_QSTAT, rd); check32("R7 empty after retire", rd, 32'h4000_0000);

    // R10 interrupt masking
    check32("R10 irq masked", {31'b0, irq}, 32'h0);
    reg_write(A_IMASK, ~(32'h1 << 13));
    #1 check32("R10 irq unmasked", {31'b0, irq}, 32'h1);
    reg_write(A_ISTS, 32'h1 << 13);
    #1 check32("R10 irq after clear", {31'b0, irq}, 32'h0);
    reg_read(A_ISTS, rd); check32("R9 single bit cleared", rd, 32'h0000_1000);
    reg_write(A_ISTS, 32'h0000_1000);
    reg_write(A_IMASK, 32'hFFFF_FFFF);

    // R4 loopback with unaligned destination
    reg_write(A_MODE, 32'h0000_0010);
    reg_read(A_MODE, rd); check32("R4 mode readback", rd, 32'h0000_0010);
    issue(32'h0000_2000, 32'h0000_3001, 3, 3, 1'b1, 1'b1);
    drain();
    reg_read(A_ISTS, rd); check32("R4 R6 loopback retire", rd, 32'h0000_3000);
    reg_write(A_ISTS, 32'hFFFF_FFFF);

    // R5 loopback across a chunk boundary
    issue(32'h0001_0000, 32'h0002_0000, 300, 300, 1'b1, 1'b1);
    drain();
    reg_read(A_ISTS, rd); check32("R5 long loopback retire", rd, 32'h0000_3000);
    reg_write(A_ISTS, 32'hFFFF_FFFF);

    // R6 zero-length command
    reg_write(A_MODE, 32'h0);
    issue(32'h0000_5000, 32'h0000_6000, 0, 0, 1'b0, 1'b1);
    drain();
    reg_read(A_ISTS, rd); check32("R6 zero length retire", rd, 32'h0000_3000);
    reg_write(A_ISTS, 32'hFFFF_FFFF);

    // R7 R8 fill the queue behind a stalled port
    stall = 1'b1;
    for (int i = 0; i < 10; i++) issue(32'h0000_4000 + 32'(i * 16), 32'h0, 1, 0, 1'b0, 1'b1);
    reg_read(A_QSTAT, rd); check32("R7 queue full", rd, 32'h8000_0000);
    issue(32'h0000_7000, 32'h0, 1, 0, 1'b0, 1'b0);
    reg_read(A_ISTS, rd); check32("R8 overflow bit", rd, 32'h0000_4000);
    stall = 1'b0;
    drain();
    reg_read(A_QSTAT, rd); check32("R7 R8 drained", rd, 32'h4000_0000);
    reg_read(A_ISTS, rd);  check32("R8 overflow kept", rd, 32'h0000_7000);
    reg_write(A_ISTS, 32'hFFFF_FFFF);

    // R5 R11 loopback switched off inside the first chunk
    reg_write(A_MODE, 32'h0000_0010);
    for (int w = 0; w < 256; w++) begin
      push_exp(1'b0, 32'h0003_0000 + 32'(w * 4), 32'h0);
      push_exp(1'b1, 32'h0004_0000 + 32'(w * 4), mem_word(32'h0003_0000 + 32'(w * 4)));
    end
    for (int w = 256; w < 300; w++) push_exp(1'b0, 32'h0003_0000 + 32'(w * 4), 32'h0);
    wr_seen = 0;
    issue(32'h0003_0000, 32'h0004_0000, 300, 300, 1'b0, 1'b0);
    wait (wr_seen > 0);
    reg_write(A_MODE, 32'h0);
    drain();
    repeat (300) @(negedge clk);
    check32("R5 access stream consumed", 32'(exp_q.size()), 32'h0);
    reg_read(A_QSTAT, rd); check32("R11 command held", rd, 32'h0);
    reg_read(A_ISTS, rd);  check32("R11 no retire", rd, 32'h0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule